// File: doc/BRIEF.md
# Word-Serial CORDIC Rotator and Vectorer

This block evaluates circular CORDIC one micro-rotation per clock on a single shared datapath: one adder/subtractor per coordinate (x, y and angle z) and one barrel shifter each for x and y. A start pulse loads the operands. Sixteen iterations follow, and a one-cycle done pulse marks the moment the results become valid on the outputs. The results then hold until the next accepted start.

In rotation mode the block ignores the supplied vector. It loads x with the reciprocal of the CORDIC gain and y with zero, so after the angle is driven to zero the outputs are the cosine and sine of the input angle. In vectoring mode it drives y to zero. It returns the gain-scaled magnitude in x, and the input angle plus the arctangent of y/x in z. All operands are 18-bit two's complement with 15 fraction bits, so 1.0 is 32768 and angles are in radians.

Top module: `cordic_engine`

## Requirements
- R1: While reset is asserted and after it is released, busy and done are both 0 until a start is accepted.
- R2: A start sampled high while busy is 0 is accepted; busy is 1 from the next cycle, and done rises exactly 16 clock edges after the accepting edge.
- R3: done is high for exactly one cycle, and busy is 0 whenever done is 1.
- R4: A start sampled while busy is 1 has no effect: the running operation keeps its mode and operands, and its result and latency do not change.
- R5: With mode = 0 (rotation) the block starts from x = 19898 (1/K in Q2.15), y = 0 and z = z_in; x_in and y_in have no effect; x_out ≈ 32768·cos(z_in/32768) and y_out ≈ 32768·sin(z_in/32768).
- R6: With mode = 1 (vectoring) the block starts from x_in, y_in, z_in; for x_in > 0, x_out ≈ 1.64676·sqrt(x_in²+y_in²) and z_out ≈ z_in + 32768·atan(y_in/x_in).
- R7: Direction d = +1 in rotation when z ≥ 0 (sign bit clear); in vectoring d = +1 when the sign bits of x and y differ. d = +1 means x−(y>>>i), y+(x>>>i), z−a(i); d = −1 uses the opposite signs.
- R8: The elementary angle a(i) = round(32768·atan(2^−i)): 25736, 15193, 8027, 4075, 2045, 1024, 512, 256, 128, 64, 32, 16, 8, 4, 2, 1 for i = 0..15.
- R9: Both shifts in iteration i are arithmetic right shifts by i of the x and y values registered at the start of that iteration, and the results wrap to 18 bits, so the outputs match that recurrence bit for bit.
- R10: x_out, y_out and z_out hold their values from done until the next accepted start.
- R11: For rotation angles within ±π/2 (±51472), |z_out| ≤ 16 when done rises; for vectoring inputs with x_in > 0 and |x_in|, |y_in| ≤ 32768, |y_out| ≤ 32 when done rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request to begin an operation, honoured only when idle |
| mode | input | 1 | 0 = rotation, 1 = vectoring |
| x_in | input | 18 | Vector x operand, Q2.15 (vectoring only) |
| y_in | input | 18 | Vector y operand, Q2.15 (vectoring only) |
| z_in | input | 18 | Angle operand, radians Q2.15 |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle pulse: results valid |
| x_out | output | 18 | cos (rotation) or scaled magnitude (vectoring) |
| y_out | output | 18 | sin (rotation) or residual y (vectoring) |
| z_out | output | 18 | Residual angle (rotation) or accumulated angle (vectoring) |

## Verification
Several properties are checked on every cycle by assertions. done lasts a single cycle and never coincides with busy, and done is always preceded by busy. The latched mode cannot change during a run, which is how an ignored start shows up internally. The residual z (rotation) or residual y (vectoring) is near zero when done rises. Other behaviours only show up in the bench's scenarios. These are the exact 16-edge latency, the bit-for-bit match to the shift-and-add recurrence, the closeness to real cosine, sine, magnitude and arctangent, the indifference to x_in and y_in in rotation, and the unchanged result after a start issued mid-run.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

  typedef enum logic {
    MODE_ROT = 1'b0,
    MODE_VEC = 1'b1
  } cordic_mode_e;

  // Elementary angles atan(2^-i) scaled by 2^15 and rounded.
  localparam int ANGLE_REF_FRAC = 15;

  // Reciprocal of the 16-step gain, 0.607252935 scaled by 2^15.
  localparam int INV_GAIN_REF = 19898;

endpackage

// File: rtl/cordic_atan_rom.sv
module cordic_atan_rom
  import cordic_pkg::*;
#(
  parameter int W    = 18,
  parameter int FRAC = 15,
  parameter int IW   = 4
) (
  input  logic [IW-1:0]       idx,
  output logic signed [W-1:0] angle
);

  localparam int DROP = ANGLE_REF_FRAC - FRAC;

  int ref_val;

  always_comb begin
    case (int'(idx))
      0:  ref_val = 25736;
      1:  ref_val = 15193;
      2:  ref_val = 8027;
      3:  ref_val = 4075;
      4:  ref_val = 2045;
      5:  ref_val = 1024;
      6:  ref_val = 512;
      7:  ref_val = 256;
      8:  ref_val = 128;
      9:  ref_val = 64;
      10: ref_val = 32;
      11: ref_val = 16;
      12: ref_val = 8;
      13: ref_val = 4;
      14: ref_val = 2;
      15: ref_val = 1;
      default: ref_val = 0;
    endcase
    angle = W'(ref_val >>> DROP);
  end

endmodule

// File: rtl/cordic_ctrl.sv
module cordic_ctrl #(
  parameter int ITER = 16,
  parameter int IW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          load,
  output logic          busy,
  output logic          done,
  output logic [IW-1:0] iter
);

  localparam logic [IW-1:0] LAST = IW'(ITER - 1);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [IW-1:0] iter_q, iter_d;
  logic          last;

  always_comb begin
    load   = start && !busy_q;
    last   = busy_q && (iter_q == LAST);
    busy_d = busy_q;
    iter_d = iter_q;
    done_d = last;
    if (load) begin
      busy_d = 1'b1;
      iter_d = '0;
    end else if (busy_q) begin
      if (last) begin
        busy_d = 1'b0;
        iter_d = '0;
      end else begin
        iter_d = iter_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      iter_q <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      iter_q <= iter_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign iter = iter_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done_q |=> !done_q); // R3
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) !(done_q && busy_q)); // R3
  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n) $rose(done_q) |-> $past(busy_q)); // R2

endmodule

// File: rtl/cordic_datapath.sv
module cordic_datapath
  import cordic_pkg::*;
#(
  parameter int W    = 18,
  parameter int FRAC = 15,
  parameter int IW   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                step,
  input  logic                mode,
  input  logic signed [W-1:0] x_in,
  input  logic signed [W-1:0] y_in,
  input  logic signed [W-1:0] z_in,
  input  logic [IW-1:0]       iter,
  input  logic signed [W-1:0] angle,
  output logic                mode_o,
  output logic signed [W-1:0] x_o,
  output logic signed [W-1:0] y_o,
  output logic signed [W-1:0] z_o
);

  localparam int INV_GAIN = INV_GAIN_REF >>> (ANGLE_REF_FRAC - FRAC);

  logic                mode_q, mode_d;
  logic signed [W-1:0] x_q, y_q, z_q;
  logic signed [W-1:0] x_d, y_d, z_d;
  logic signed [W-1:0] x_sh, y_sh;
  logic                dir_pos;

  always_comb begin
    x_sh    = x_q >>> iter;
    y_sh    = y_q >>> iter;
    dir_pos = (mode_q == MODE_VEC) ? (x_q[W-1] ^ y_q[W-1]) : !z_q[W-1];
    mode_d  = mode_q;
    x_d     = x_q;
    y_d     = y_q;
    z_d     = z_q;
    if (load) begin
      mode_d = mode;
      z_d    = z_in;
      if (mode == MODE_VEC) begin
        x_d = x_in;
        y_d = y_in;
      end else begin
        x_d = W'(INV_GAIN);
        y_d = '0;
      end
    end else if (step) begin
      if (dir_pos) begin
        x_d = x_q - y_sh;
        y_d = y_q + x_sh;
        z_d = z_q - angle;
      end else begin
        x_d = x_q + y_sh;
        y_d = y_q - x_sh;
        z_d = z_q + angle;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      x_q    <= '0;
      y_q    <= '0;
      z_q    <= '0;
    end else if (load || step) begin
      mode_q <= mode_d;
      x_q    <= x_d;
      y_q    <= y_d;
      z_q    <= z_d;
    end
  end

  assign mode_o = mode_q;
  assign x_o    = x_q;
  assign y_o    = y_q;
  assign z_o    = z_q;

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n) (step && !load) |=> $stable(mode_q)); // R4
  AST_ROT_START_Y: assert property (@(posedge clk) disable iff (!rst_n) (load && mode == MODE_ROT) |=> (y_q == '0)); // R5

endmodule

// File: rtl/cordic_engine.sv
module cordic_engine
  import cordic_pkg::*;
#(
  parameter int W    = 18,
  parameter int FRAC = 15,
  parameter int ITER = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                mode,
  input  logic signed [W-1:0] x_in,
  input  logic signed [W-1:0] y_in,
  input  logic signed [W-1:0] z_in,
  output logic                busy,
  output logic                done,
  output logic signed [W-1:0] x_out,
  output logic signed [W-1:0] y_out,
  output logic signed [W-1:0] z_out
);

  localparam int IW = (ITER > 1) ? $clog2(ITER) : 1;
  localparam logic [W-1:0] ROT_RESID_MAX = W'(16);
  localparam logic [W-1:0] VEC_RESID_MAX = W'(32);

  logic [1:0]          rst_sync_q;
  logic                core_rst_n;
  logic                load;
  logic [IW-1:0]       iter;
  logic signed [W-1:0] angle;
  logic                mode_run;
  logic [W-1:0]        z_abs, y_abs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  cordic_ctrl #(.ITER(ITER), .IW(IW)) u_ctrl (
    .clk   (clk),
    .rst_n (core_rst_n),
    .start (start),
    .load  (load),
    .busy  (busy),
    .done  (done),
    .iter  (iter)
  );

  cordic_atan_rom #(.W(W), .FRAC(FRAC), .IW(IW)) u_rom (
    .idx   (iter),
    .angle (angle)
  );

  cordic_datapath #(.W(W), .FRAC(FRAC), .IW(IW)) u_dp (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .load   (load),
    .step   (busy),
    .mode   (mode),
    .x_in   (x_in),
    .y_in   (y_in),
    .z_in   (z_in),
    .iter   (iter),
    .angle  (angle),
    .mode_o (mode_run),
    .x_o    (x_out),
    .y_o    (y_out),
    .z_o    (z_out)
  );

  assign z_abs = z_out[W-1] ? W'(-z_out) : z_out;
  assign y_abs = y_out[W-1] ? W'(-y_out) : y_out;

  AST_ROT_CONVERGED: assert property (@(posedge clk) disable iff (!core_rst_n) (done && mode_run == MODE_ROT) |-> (z_abs <= ROT_RESID_MAX)); // R11
  AST_VEC_CONVERGED: assert property (@(posedge clk) disable iff (!core_rst_n) (done && mode_run == MODE_VEC) |-> (y_abs <= VEC_RESID_MAX)); // R11

endmodule

// File: tb/cordic_engine_tb.sv
module cordic_engine_tb;

  localparam int  W       = 18;
  localparam real SCALE   = 32768.0;
  localparam real GAIN    = 1.6467602;
  localparam int  HALF_PI = 51472;

  logic                clk;
  logic                rst_n;
  logic                start;
  logic                mode;
  logic signed [W-1:0] x_in, y_in, z_in;
  logic                busy, done;
  logic signed [W-1:0] x_out, y_out, z_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  int atab [16] = '{25736, 15193, 8027, 4075, 2045, 1024, 512, 256,
                    128, 64, 32, 16, 8, 4, 2, 1};

  cordic_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .x_in(x_in), .y_in(y_in), .z_in(z_in),
    .busy(busy), .done(done), .x_out(x_out), .y_out(y_out), .z_out(z_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model(input logic m, input logic signed [W-1:0] xi, yi, zi,
                       output logic signed [W-1:0] xo, yo, zo);
    logic signed [W-1:0] xv, yv, zv, xs, ys, an;
    bit pos;
    xv = m ? xi : W'(19898);
    yv = m ? yi : '0;
    zv = zi;
    for (int i = 0; i < 16; i++) begin
      xs  = xv >>> i;
      ys  = yv >>> i;
      an  = W'(atab[i]);
      pos = m ? (xv[W-1] ^ yv[W-1]) : !zv[W-1];
      if (pos) begin
        xv = xv - ys; yv = yv + xs; zv = zv - an;
      end else begin
        xv = xv + ys; yv = yv - xs; zv = zv + an;
      end
    end
    xo = xv; yo = yv; zo = zv;
  endtask

  function automatic bit near(input int a, input real e, input real tol);
    real d;
    d = real'(a) - e;
    if (d < 0.0) d = -d;
    return d <= tol;
  endfunction

  // Issue one operation; returns the number of edges from acceptance to done.
  task automatic run_op(input logic m, input int xi, yi, zi, output int lat);
    @(negedge clk);
    mode = m; x_in = W'(xi); y_in = W'(yi); z_in = W'(zi); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic full_check(input logic m, input int xi, yi, zi, input bit real_chk);
    int lat;
    logic signed [W-1:0] ex, ey, ez;
    real ang;
    run_op(m, xi, yi, zi, lat);
    model(m, W'(xi), W'(yi), W'(zi), ex, ey, ez);
    check(lat == 16, "R2 latency", lat, 16);
    check(x_out == ex && y_out == ey && z_out == ez, m ? "R6/R7/R8/R9 bit-exact x" : "R5/R7/R8/R9 bit-exact x",
          int'(x_out), int'(ex));
    if (real_chk) begin
      if (!m) begin
        ang = real'(zi) / SCALE;
        check(near(int'(x_out), $cos(ang) * SCALE, 24.0), "R5 cos", int'(x_out), int'($cos(ang) * SCALE));
        check(near(int'(y_out), $sin(ang) * SCALE, 24.0), "R5 sin", int'(y_out), int'($sin(ang) * SCALE));
      end else begin
        check(near(int'(x_out), GAIN * $sqrt(real'(xi) * real'(xi) + real'(yi) * real'(yi)), 24.0),
              "R6 magnitude", int'(x_out),
              int'(GAIN * $sqrt(real'(xi) * real'(xi) + real'(yi) * real'(yi))));
        check(near(int'(z_out), real'(zi) + $atan2(real'(yi), real'(xi)) * SCALE, 24.0),
              "R6 arctangent", int'(z_out), int'(real'(zi) + $atan2(real'(yi), real'(xi)) * SCALE));
      end
    end
  endtask

  initial begin
    #3_000_000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int lat;
    logic signed [W-1:0] ex, ey, ez, hx, hy, hz;
    void'($urandom(32'd4242));
    rst_n = 1'b0; start = 1'b0; mode = 1'b0; x_in = '0; y_in = '0; z_in = '0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R1 in reset", int'({busy, done}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R1 after reset", int'({busy, done}), 0);

    // Directed rotation corners
    full_check(1'b0, 0, 0, 0, 1'b1);
    full_check(1'b0, 0, 0, HALF_PI, 1'b1);
    full_check(1'b0, 0, 0, -HALF_PI, 1'b1);
    full_check(1'b0, 0, 0, 17157, 1'b1);

    // R3: done lasts one cycle, busy low with done
    run_op(1'b0, 0, 0, 12000, lat);
    check(done && !busy, "R3 busy low at done", int'(busy), 0);
    @(negedge clk);
    check(!done, "R3 done one cycle", int'(done), 0);

    // R10: results hold after done
    hx = x_out; hy = y_out; hz = z_out;
    repeat (7) @(negedge clk);
    check(x_out == hx && y_out == hy && z_out == hz, "R10 hold", int'(x_out), int'(hx));

    // R5: x_in/y_in ignored in rotation
    run_op(1'b0, 0, 0, -23000, lat);
    hx = x_out; hy = y_out;
    run_op(1'b0, 98765, -54321, -23000, lat);
    check(x_out == hx && y_out == hy, "R5 x_in/y_in ignored", int'(x_out), int'(hx));

    // Directed vectoring corners
    full_check(1'b1, 32768, 0, 0, 1'b1);
    full_check(1'b1, 32768, 32768, 0, 1'b1);
    full_check(1'b1, 32768, -32768, 0, 1'b1);
    full_check(1'b1, 1, 32768, 0, 1'b0);
    full_check(1'b1, 20000, 9000, 1000, 1'b1);

    // R4: start while busy ignored
    model(1'b1, W'(25000), W'(-7000), W'(0), ex, ey, ez);
    @(negedge clk);
    mode = 1'b1; x_in = W'(25000); y_in = W'(-7000); z_in = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    repeat (5) begin @(negedge clk); lat++; end
    mode = 1'b0; x_in = W'(111); y_in = W'(222); z_in = W'(3333); start = 1'b1;
    @(negedge clk);
    lat++;
    start = 1'b0;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    check(lat == 16, "R4 latency unchanged", lat, 16);
    check(x_out == ex && y_out == ey && z_out == ez, "R4 result unchanged", int'(z_out), int'(ez));

    // Random rotations
    for (int k = 0; k < 40; k++) begin
      int zr;
      zr = int'($urandom_range(0, 2 * HALF_PI)) - HALF_PI;
      full_check(1'b0, int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)), zr, 1'b1);
    end
    // Random vectorings
    for (int k = 0; k < 40; k++) begin
      int xr, yr;
      xr = int'($urandom_range(4096, 32768));
      yr = int'($urandom_range(0, 65536)) - 32768;
      full_check(1'b1, xr, yr, 0, 1'b1);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule